// File: doc/BRIEF.md
# Initialization block loader

This block brings a network controller from its stopped state to a configured state. When the control logic raises the initialize request, the loader forms a 24-bit base address from two register values. It then reads a fixed block of twelve 16-bit words from buffer memory, one word per handshake, and splits the words into the controller's configuration. That configuration is the mode word, the 48-bit station address, the 64-bit multicast filter, and the base address and entry count of the receive and transmit descriptor rings.

After the last word arrives, the loader raises a one-cycle completion strobe. The surrounding register file uses that strobe to set its "initialization done" flag, clear its initialize request bit, and return both ring pointers to entry zero. In the same cycle the loader updates its transmit-enable and receive-enable outputs from two bits of the mode word. If the base address is odd, the loader flags a misalignment, but it still fetches from that address.

Top module: `init_block_loader`

## Requirements
- R1: A low-to-high change of `init_req` while the loader is idle starts a fetch, and `busy` is high from the next cycle. A rise of `init_req` while `busy` is high has no effect. Holding `init_req` high after completion does not start another fetch.
- R2: The base address is `{base_hi, base_lo}`. Word i (i = 0 to 11) is requested in ascending order at byte address base + 2·i, modulo 2^24.
- R3: `rd_req` and `rd_addr` stay unchanged until `rd_valid` is seen high while `rd_req` is high. A word is taken in that cycle, whatever the number of cycles the memory waited.
- R4: Byte order is little-endian: `rd_data[7:0]` is the byte at `rd_addr` and `rd_data[15:8]` is the byte at `rd_addr`+1. `mode_word` is word 0, `station_addr` is {word3, word2, word1} and `addr_filter` is {word7, word6, word5, word4}.
- R5: `rx_ring_base` = {word9[7:0], word8} and `rx_ring_len` = 1 << word9[15:13]. `tx_ring_base` = {word11[7:0], word10} and `tx_ring_len` = 1 << word11[15:13].
- R6: `done` is high for exactly one cycle: the cycle after the twelfth word is taken. `busy` is low in that cycle, and every configuration output already holds the new block's value.
- R7: In the `done` cycle, `tx_on` = NOT `mode_word[1]` and `rx_on` = NOT `mode_word[0]`. At all other times both hold their value.
- R8: `misalign` equals bit 0 of `base_lo` as sampled when the fetch started, and it keeps that value until the next start.
- R9: After reset, `busy`, `rd_req`, `done`, `misalign`, `tx_on` and `rx_on` are 0, all configuration words are 0, and both ring lengths are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req | input | 1 | Initialize request bit; its rising edge starts a fetch |
| base_lo | input | 16 | Low 16 bits of the block base address |
| base_hi | input | 8 | Upper 8 bits of the block base address |
| busy | output | 1 | High while the block is being fetched |
| misalign | output | 1 | Base address of the last start was odd |
| rd_req | output | 1 | Word read request |
| rd_addr | output | 24 | Byte address of the requested word |
| rd_valid | input | 1 | Read data valid; completes the request |
| rd_data | input | 16 | Read word, little-endian |
| done | output | 1 | One-cycle completion strobe (set done flag, clear request, reset ring pointers) |
| tx_on | output | 1 | Transmit path enable |
| rx_on | output | 1 | Receive path enable |
| mode_word | output | 16 | Mode word |
| station_addr | output | 48 | Station address |
| addr_filter | output | 64 | Multicast address filter |
| rx_ring_base | output | 24 | Receive ring base address |
| rx_ring_len | output | 8 | Receive ring entry count |
| tx_ring_base | output | 24 | Transmit ring base address |
| tx_ring_len | output | 8 | Transmit ring entry count |

## Verification
The bench builds the block with its package defaults: a 24-bit address, twelve 16-bit words and 3-bit ring codes. At these values the sweep can cover every combination of the two mode-disable bits with all eight ring-size codes. Each of the 32 block fetches uses a read latency of 0 to 3 cycles and a different base address. Further runs cover an odd base that wraps past the top of the 24-bit space, and a request edge that arrives in the middle of a fetch.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  localparam int ADDR_W    = 24;
  localparam int LO_W      = 16;
  localparam int HI_W      = ADDR_W - LO_W;
  localparam int WORD_W    = 16;
  localparam int BLK_WORDS = 12;
  localparam int IDX_W     = $clog2(BLK_WORDS);
  localparam int CODE_W    = 3;
  localparam int LEN_W     = 1 << CODE_W;
  localparam int STA_WORDS = 3;
  localparam int FLT_WORDS = 4;

  // word positions inside the block (decoded by the field latch)
  localparam logic [IDX_W-1:0] IX_MODE = IDX_W'(0);
  localparam logic [IDX_W-1:0] IX_STA  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IX_FLT  = IDX_W'(4);
  localparam logic [IDX_W-1:0] IX_RXLO = IDX_W'(8);
  localparam logic [IDX_W-1:0] IX_RXHI = IDX_W'(9);
  localparam logic [IDX_W-1:0] IX_TXLO = IDX_W'(10);
  localparam logic [IDX_W-1:0] IX_TXHI = IDX_W'(11);
  localparam logic [IDX_W-1:0] IX_LAST = IDX_W'(BLK_WORDS - 1);

  function automatic logic [ADDR_W-1:0] block_base(input logic [LO_W-1:0] lo,
                                                   input logic [HI_W-1:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W-1:0] idx);
    return base + ADDR_W'({idx, 1'b0});
  endfunction

  function automatic logic [LEN_W-1:0] ring_count(input logic [CODE_W-1:0] code);
    return LEN_W'(1) << code;
  endfunction

  function automatic logic mode_tx_en(input logic [WORD_W-1:0] m);
    return !m[1];
  endfunction

  function automatic logic mode_rx_en(input logic [WORD_W-1:0] m);
    return !m[0];
  endfunction
endpackage

// File: rtl/cbl_fetch.sv
module cbl_fetch
  import cbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic [LO_W-1:0]   base_lo,
  input  logic [HI_W-1:0]   base_hi,
  input  logic              rd_valid,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic              misalign,
  output logic              word_cap,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              last_cap,
  output logic              done
);
  logic              fetching;
  logic              init_prev;
  logic              misalign_q;
  logic              done_q;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] base_q;
  logic              init_rise;
  logic              start;

  assign init_rise = init_req & ~init_prev;
  assign start     = init_rise & ~fetching;
  assign word_cap  = fetching & rd_valid;
  assign last_cap  = word_cap & (idx == IX_LAST);
  assign cap_idx   = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetching   <= 1'b0;
      init_prev  <= 1'b0;
      misalign_q <= 1'b0;
      done_q     <= 1'b0;
      idx        <= '0;
      base_q     <= '0;
    end else begin
      init_prev <= init_req;
      done_q    <= last_cap;
      if (start) begin
        fetching   <= 1'b1;
        idx        <= '0;
        base_q     <= block_base(base_lo, base_hi);
        misalign_q <= base_lo[0];
      end else if (word_cap) begin
        if (last_cap) fetching <= 1'b0;
        else          idx      <= idx + IDX_W'(1);
      end
    end
  end

  assign rd_req   = fetching;
  assign rd_addr  = word_addr(base_q, idx);
  assign busy     = fetching;
  assign misalign = misalign_q;
  assign done     = done_q;

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_cap && !last_cap) |=> (rd_addr == $past(rd_addr) + ADDR_W'(2)));

  assert_misalign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (misalign == $past(base_lo[0])));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(last_cap)));
endmodule

// File: rtl/cbl_fields.sv
module cbl_fields
  import cbl_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          word_cap,
  input  logic                          last_cap,
  input  logic [IDX_W-1:0]              cap_idx,
  input  logic [WORD_W-1:0]             rd_data,
  output logic [WORD_W-1:0]             mode_word,
  output logic [STA_WORDS*WORD_W-1:0]   station_addr,
  output logic [FLT_WORDS*WORD_W-1:0]   addr_filter,
  output logic [ADDR_W-1:0]             rx_ring_base,
  output logic [LEN_W-1:0]              rx_ring_len,
  output logic [ADDR_W-1:0]             tx_ring_base,
  output logic [LEN_W-1:0]              tx_ring_len,
  output logic                          tx_on,
  output logic                          rx_on
);
  logic [WORD_W-1:0] mode_q;
  logic [WORD_W-1:0] sta_w [STA_WORDS];
  logic [WORD_W-1:0] flt_w [FLT_WORDS];
  logic [LO_W-1:0]   rx_lo, tx_lo;
  logic [HI_W-1:0]   rx_hi, tx_hi;
  logic [CODE_W-1:0] rx_code, tx_code;
  logic              tx_q, rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      rx_lo   <= '0;
      rx_hi   <= '0;
      rx_code <= '0;
      tx_lo   <= '0;
      tx_hi   <= '0;
      tx_code <= '0;
      tx_q    <= 1'b0;
      rx_q    <= 1'b0;
    end else begin
      if (word_cap) begin
        case (cap_idx)
          IX_MODE: mode_q <= rd_data;
          IX_RXLO: rx_lo  <= rd_data;
          IX_RXHI: begin
            rx_hi   <= rd_data[HI_W-1:0];
            rx_code <= rd_data[WORD_W-1 -: CODE_W];
          end
          IX_TXLO: tx_lo  <= rd_data;
          IX_TXHI: begin
            tx_hi   <= rd_data[HI_W-1:0];
            tx_code <= rd_data[WORD_W-1 -: CODE_W];
          end
          default: ;
        endcase
      end
      if (last_cap) begin
        tx_q <= mode_tx_en(mode_q);
        rx_q <= mode_rx_en(mode_q);
      end
    end
  end

  for (genvar g = 0; g < STA_WORDS; g++) begin : g_sta
    localparam logic [IDX_W-1:0] MY_IX = IX_STA + IDX_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          sta_w[g] <= '0;
      else if (word_cap && cap_idx == MY_IX) sta_w[g] <= rd_data;
    end
    assign station_addr[g*WORD_W +: WORD_W] = sta_w[g];
  end

  for (genvar g = 0; g < FLT_WORDS; g++) begin : g_flt
    localparam logic [IDX_W-1:0] MY_IX = IX_FLT + IDX_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flt_w[g] <= '0;
      else if (word_cap && cap_idx == MY_IX) flt_w[g] <= rd_data;
    end
    assign addr_filter[g*WORD_W +: WORD_W] = flt_w[g];
  end

  assign mode_word    = mode_q;
  assign rx_ring_base = block_base(rx_lo, rx_hi);
  assign tx_ring_base = block_base(tx_lo, tx_hi);
  assign rx_ring_len  = ring_count(rx_code);
  assign tx_ring_len  = ring_count(tx_code);
  assign tx_on        = tx_q;
  assign rx_on        = rx_q;

  assert_on_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !last_cap |=> ($stable(tx_on) && $stable(rx_on)));
endmodule

// File: rtl/init_block_loader.sv
module init_block_loader
  import cbl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_req,
  input  logic [15:0] base_lo,
  input  logic [7:0]  base_hi,
  output logic        busy,
  output logic        misalign,
  output logic        rd_req,
  output logic [23:0] rd_addr,
  input  logic        rd_valid,
  input  logic [15:0] rd_data,
  output logic        done,
  output logic        tx_on,
  output logic        rx_on,
  output logic [15:0] mode_word,
  output logic [47:0] station_addr,
  output logic [63:0] addr_filter,
  output logic [23:0] rx_ring_base,
  output logic [7:0]  rx_ring_len,
  output logic [23:0] tx_ring_base,
  output logic [7:0]  tx_ring_len
);
  logic             word_cap;
  logic             last_cap;
  logic [IDX_W-1:0] cap_idx;

  cbl_fetch u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_req (init_req),
    .base_lo  (base_lo),
    .base_hi  (base_hi),
    .rd_valid (rd_valid),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .busy     (busy),
    .misalign (misalign),
    .word_cap (word_cap),
    .cap_idx  (cap_idx),
    .last_cap (last_cap),
    .done     (done)
  );

  cbl_fields u_fields (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_cap     (word_cap),
    .last_cap     (last_cap),
    .cap_idx      (cap_idx),
    .rd_data      (rd_data),
    .mode_word    (mode_word),
    .station_addr (station_addr),
    .addr_filter  (addr_filter),
    .rx_ring_base (rx_ring_base),
    .rx_ring_len  (rx_ring_len),
    .tx_ring_base (tx_ring_base),
    .tx_ring_len  (tx_ring_len),
    .tx_on        (tx_on),
    .rx_on        (rx_on)
  );

  assert_enables_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tx_on == !mode_word[1] && rx_on == !mode_word[0]));

  assert_single_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && init_req) |=> !busy);
endmodule

// File: tb/sim_init_block_loader.sv
module sim_init_block_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_req = 1'b0;
  logic [15:0] base_lo = '0;
  logic [7:0]  base_hi = '0;
  logic        busy, misalign, rd_req, done, tx_on, rx_on;
  logic [23:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_data = '0;
  logic [15:0] mode_word;
  logic [47:0] station_addr;
  logic [63:0] addr_filter;
  logic [23:0] rx_ring_base, tx_ring_base;
  logic [7:0]  rx_ring_len, tx_ring_len;

  always #10 clk = ~clk;

  init_block_loader u0 (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .base_lo(base_lo), .base_hi(base_hi),
    .busy(busy), .misalign(misalign), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .tx_on(tx_on), .rx_on(rx_on),
    .mode_word(mode_word), .station_addr(station_addr), .addr_filter(addr_filter),
    .rx_ring_base(rx_ring_base), .rx_ring_len(rx_ring_len),
    .tx_ring_base(tx_ring_base), .tx_ring_len(tx_ring_len)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit reported = 0;
  logic [15:0] img [12];
  logic [23:0] base_g = '0;
  int lat_g = 0;
  int k_acc = 0;
  int addr_err = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(input logic [23:0] a);
    logic [23:0] off = a - base_g;
    int i = int'(off[23:1]);
    if (i >= 12) return 8'hEE;
    return off[0] ? img[i][15:8] : img[i][7:0];
  endfunction

  function automatic logic [7:0] pow2(input logic [2:0] code);
    logic [7:0] v = 8'd1;
    for (int j = 0; j < int'(code); j++) v = v * 8'd2;
    return v;
  endfunction

  // memory responder: little-endian bytes, programmable latency
  initial begin
    int wc = 0;
    forever begin
      @(negedge clk);
      if (rd_req) begin
        if (rd_addr !== base_g + 24'(2 * k_acc)) addr_err++;
        if (wc >= lat_g) begin
          rd_valid = 1'b1;
          rd_data  = {byte_at(rd_addr + 24'd1), byte_at(rd_addr)};
          k_acc++;
          wc = 0;
        end else begin
          rd_valid = 1'b0;
          wc++;
        end
      end else begin
        rd_valid = 1'b0;
        wc = 0;
      end
    end
  end

  task automatic run_one(input logic [23:0] base, input int lat, input logic [1:0] m,
                         input logic [2:0] rc, input bit poke);
    int cyc = 0;
    int dones = 0;
    int restart = 0;
    logic [2:0] tc = 3'd7 - rc;
    for (int i = 0; i < 12; i++)
      img[i] = 16'(i * 16'h1357) ^ {rc, 11'h0, m} ^ 16'h2468;
    img[0]  = {8'hC3 ^ {5'b0, rc}, 6'h2A, m};
    img[9]  = {rc, 5'h11, base[7:0] ^ 8'h5A};
    img[11] = {tc, 5'h06, 8'hA5 ^ {5'b0, rc}};
    base_g = base; lat_g = lat; k_acc = 0; addr_err = 0;
    @(negedge clk);
    base_lo = base[15:0]; base_hi = base[23:16]; init_req = 1'b1;
    @(negedge clk);
    chk(busy === 1'b1, "R1 busy after start", 64'(busy), 64'd1);
    chk(misalign === base[0], "R8 misalign", 64'(misalign), 64'(base[0]));
    if (poke) begin
      init_req = 1'b0;
      @(negedge clk);
      init_req = 1'b1;
    end
    while (cyc < 400 && done !== 1'b1) begin
      @(negedge clk);
      cyc++;
    end
    chk(done === 1'b1, "R6 done seen", 64'(done), 64'd1);
    chk(busy === 1'b0, "R6 busy low at done", 64'(busy), 64'd0);
    chk(mode_word === img[0], "R4 mode word", 64'(mode_word), 64'(img[0]));
    chk(station_addr === {img[3], img[2], img[1]}, "R4 station", 64'(station_addr),
        64'({img[3], img[2], img[1]}));
    chk(addr_filter === {img[7], img[6], img[5], img[4]}, "R4 filter", addr_filter,
        {img[7], img[6], img[5], img[4]});
    chk(rx_ring_base === {img[9][7:0], img[8]}, "R5 rx base", 64'(rx_ring_base),
        64'({img[9][7:0], img[8]}));
    chk(tx_ring_base === {img[11][7:0], img[10]}, "R5 tx base", 64'(tx_ring_base),
        64'({img[11][7:0], img[10]}));
    chk(rx_ring_len === pow2(rc), "R5 rx len", 64'(rx_ring_len), 64'(pow2(rc)));
    chk(tx_ring_len === pow2(tc), "R5 tx len", 64'(tx_ring_len), 64'(pow2(tc)));
    chk(tx_on === ~m[1], "R7 tx_on", 64'(tx_on), 64'(~m[1]));
    chk(rx_on === ~m[0], "R7 rx_on", 64'(rx_on), 64'(~m[0]));
    dones = 1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (done) dones++;
      if (busy) restart++;
    end
    chk(dones == 1, "R6 single done", 64'(dones), 64'd1);
    chk(restart == 0, "R1 no restart while held", 64'(restart), 64'd0);
    chk(tx_on === ~m[1] && rx_on === ~m[0], "R7 enables held", 64'({tx_on, rx_on}),
        64'({~m[1], ~m[0]}));
    chk(k_acc == 12, "R3 word count", 64'(k_acc), 64'd12);
    chk(addr_err == 0, "R2 addresses", 64'(addr_err), 64'd0);
    init_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!reported) begin
      reported = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(busy === 1'b0 && rd_req === 1'b0 && done === 1'b0, "R9 control idle",
        64'({busy, rd_req, done}), 64'd0);
    chk(misalign === 1'b0 && tx_on === 1'b0 && rx_on === 1'b0, "R9 flags clear",
        64'({misalign, tx_on, rx_on}), 64'd0);
    chk(mode_word === '0 && station_addr === '0 && addr_filter === '0, "R9 config zero",
        64'(mode_word), 64'd0);
    chk(rx_ring_base === '0 && tx_ring_base === '0, "R9 ring bases zero",
        64'({rx_ring_base, tx_ring_base}), 64'd0);
    chk(rx_ring_len === 8'd1 && tx_ring_len === 8'd1, "R9 ring lengths one",
        64'({rx_ring_len, tx_ring_len}), 64'h0101);
    for (int m = 0; m < 4; m++)
      for (int rc = 0; rc < 8; rc++)
        run_one({8'(rc * 8'h13), 16'h0400 + 16'(m * 16'h0102)}, (m + rc) % 4,
                2'(m), 3'(rc), rc == 5);
    // odd base wrapping past the top of the address space (R8, R2)
    run_one(24'hFFFFF1, 1, 2'b10, 3'd3, 1'b0);
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule